// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare and Select Unit

This unit performs the non-arithmetic operations on two 32-bit IEEE-754 single-precision words: minimum, maximum, three compares (equal, less-than, less-or-equal), three sign-injection forms and classification. The operation is selected by a 7-bit major code and a 3-bit minor code, laid out like a floating-point instruction of a RISC-V style core. The result word is produced combinationally in the same cycle as the operands and the operation code. Before any operation, a subnormal operand is replaced by a zero that keeps its sign.

Each valid, legal operation can raise exception bits. These bits are OR-ed into a sticky 5-bit flag register. The flag register is shown on an output at all times. A clear strobe zeroes the register at the next clock edge, so software reads the value and clears it in the same cycle. An encoding outside the supported set is reported as illegal, produces a zero result and leaves the flags alone.

Top module: `fp_cmpsel`

## Requirements
- R1: The encodings are {funct7,funct3}: 0010100/000 min, 0010100/001 max, 1010000/010 equal, 1010000/001 less-than, 1010000/000 less-or-equal, 0010000/000 sign copy, 0010000/001 sign negate, 0010000/010 sign XOR, 1110000/001 classify. Any other pair drives `illegal_op` high and `result` to 0. For a listed pair, `illegal_op` is 0.
- R2: An operand with exponent 0 and a nonzero mantissa is replaced by a zero of the same sign before every operation.
- R3: When both operands of min or max are NaN, the result is 0x7FC00000. When exactly one is NaN, the result is the other (flushed) operand.
- R4: Min and max order -0 below +0. For 0x80000000 and 0x00000000 in either order, min returns 0x80000000 and max returns 0x00000000. Otherwise they return the numerically smaller or larger operand.
- R5: Equal, less-than and less-or-equal return 0 when either operand is NaN. Otherwise they return 1 or 0 from the numeric comparison, with +0 equal to -0. Bits 31:1 of the result are always 0.
- R6: Sign injection returns bits 30:0 of flushed operand A. Bit 31 is B's sign for copy, the inverted B sign for negate, or the XOR of both signs for XOR.
- R7: Classify returns a one-hot mask in bits 9:0, and bits 31:10 are 0. The bit assignment is: 0 -inf, 1 -normal, 2 -subnormal, 3 -0, 4 +0, 5 +subnormal, 6 +normal, 7 +inf, 8 signaling NaN, 9 quiet NaN. A NaN is quiet when mantissa bit 22 is 1. Bits 2 and 5 never appear, because operands are flushed.
- R8: The flag vector layout is bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. Invalid is raised by min, max and equal on a signaling NaN operand, and by less-than and less-or-equal on any NaN operand. Bits 4:1 never become 1.
- R9: On a clock edge with `op_valid` high, a legal encoding and `flag_clr` low, the new flag bits are OR-ed into `fflags`. Without a valid legal operation, `fflags` holds its value.
- R10: A clock edge with `flag_clr` high loads `fflags` with only the flag bits raised by that same cycle's operation. This is 0 when no valid legal operation raises a flag.
- R11: After reset, `fflags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present; enables flag accumulation |
| funct7 | input | 7 | Major operation code |
| funct3 | input | 3 | Minor operation code |
| src_a | input | 32 | Operand A (single precision) |
| src_b | input | 32 | Operand B (single precision) |
| flag_clr | input | 1 | Read-and-clear strobe for the flag register |
| result | output | 32 | Operation result |
| illegal_op | output | 1 | Encoding not supported |
| fflags | output | 5 | Sticky exception flags |

## Verification
Several properties are checked on every cycle: the zero result on an illegal encoding, a one-hot classify mask with the subnormal bits clear, a 0/1-only compare result, and min/max returning one of the two flushed operands when not both are NaN. The flag register is also checked every cycle: it never drops a bit without a clear, holds without a valid legal operation, empties on a clear with nothing new, and never sets a bit other than invalid. The exact numeric ordering, the handling of -0 against +0, quiet versus signaling NaN, the sign-injection bits and the flushing of subnormals can only be shown by the bench. It compares results against its own model, driven by random special-value operands and directed corner cases.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
  localparam int FP_W      = 32;
  localparam int MAN_W     = 23;
  localparam int EXP_W     = FP_W - MAN_W - 1;
  localparam int SIGN_BIT  = FP_W - 1;
  localparam int EXP_LSB   = MAN_W;
  localparam int QUIET_BIT = MAN_W - 1;
  localparam int FLAG_W    = 5;
  localparam int FLG_NV    = 0;
  localparam int CLASS_W   = 10;
  localparam int F7_W      = 7;
  localparam int F3_W      = 3;

  localparam logic [F7_W-1:0] F7_MINMAX = 7'b0010100;
  localparam logic [F7_W-1:0] F7_CMP    = 7'b1010000;
  localparam logic [F7_W-1:0] F7_SGN    = 7'b0010000;
  localparam logic [F7_W-1:0] F7_CLASS  = 7'b1110000;

  localparam logic [FP_W-1:0] CANON_NAN = 32'h7FC0_0000;

  typedef logic [FP_W-1:0] fp_word_t;

  typedef enum logic [3:0] {
    OP_MIN, OP_MAX, OP_FEQ, OP_FLT, OP_FLE,
    OP_SGNJ, OP_SGNJN, OP_SGNJX, OP_CLASS, OP_NONE
  } op_e;

  function automatic logic [EXP_W-1:0] exp_of(fp_word_t x);
    return x[SIGN_BIT-1:EXP_LSB];
  endfunction

  function automatic logic is_nan(fp_word_t x);
    return (&exp_of(x)) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic is_snan(fp_word_t x);
    return is_nan(x) && !x[QUIET_BIT];
  endfunction

  function automatic logic is_inf(fp_word_t x);
    return (&exp_of(x)) && !(|x[MAN_W-1:0]);
  endfunction

  function automatic logic is_zero(fp_word_t x);
    return !(|x[SIGN_BIT-1:0]);
  endfunction

  // subnormal -> signed zero
  function automatic fp_word_t flush(fp_word_t x);
    fp_word_t r;
    r = x;
    if (!(|exp_of(x))) r = {x[SIGN_BIT], {(FP_W-1){1'b0}}};
    return r;
  endfunction

  function automatic logic fp_lt(fp_word_t a, fp_word_t b);
    logic r;
    if (is_nan(a) || is_nan(b))            r = 1'b0;
    else if (is_zero(a) && is_zero(b))     r = 1'b0;
    else if (a[SIGN_BIT] != b[SIGN_BIT])   r = a[SIGN_BIT];
    else if (!a[SIGN_BIT])                 r = a[SIGN_BIT-1:0] < b[SIGN_BIT-1:0];
    else                                   r = a[SIGN_BIT-1:0] > b[SIGN_BIT-1:0];
    return r;
  endfunction

  function automatic logic fp_eq(fp_word_t a, fp_word_t b);
    return !is_nan(a) && !is_nan(b) && ((a == b) || (is_zero(a) && is_zero(b)));
  endfunction

  function automatic logic [CLASS_W-1:0] classify(fp_word_t x);
    logic [CLASS_W-1:0] m;
    logic s;
    m = '0;
    s = x[SIGN_BIT];
    if (is_inf(x))               m[s ? 0 : 7] = 1'b1;
    else if (is_nan(x))          m[x[QUIET_BIT] ? 9 : 8] = 1'b1;
    else if (is_zero(x))         m[s ? 3 : 4] = 1'b1;
    else if (!(|exp_of(x)))      m[s ? 2 : 5] = 1'b1;
    else                         m[s ? 1 : 6] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpcs_decode.sv
module fpcs_decode
  import fpcs_pkg::*;
(
  input  logic [F7_W-1:0] funct7_i,
  input  logic [F3_W-1:0] funct3_i,
  output op_e             op_o,
  output logic            legal_o
);
  always_comb begin
    op_o = OP_NONE;
    unique case (funct7_i)
      F7_MINMAX: begin
        if (funct3_i == 3'b000)      op_o = OP_MIN;
        else if (funct3_i == 3'b001) op_o = OP_MAX;
      end
      F7_CMP: begin
        if (funct3_i == 3'b010)      op_o = OP_FEQ;
        else if (funct3_i == 3'b001) op_o = OP_FLT;
        else if (funct3_i == 3'b000) op_o = OP_FLE;
      end
      F7_SGN: begin
        if (funct3_i == 3'b000)      op_o = OP_SGNJ;
        else if (funct3_i == 3'b001) op_o = OP_SGNJN;
        else if (funct3_i == 3'b010) op_o = OP_SGNJX;
      end
      F7_CLASS: begin
        if (funct3_i == 3'b001)      op_o = OP_CLASS;
      end
      default: op_o = OP_NONE;
    endcase
    legal_o = (op_o != OP_NONE);
  end
endmodule

// File: rtl/fpcs_core.sv
module fpcs_core
  import fpcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_e      op_i,
  input  fp_word_t src_a_i,
  input  fp_word_t src_b_i,
  output fp_word_t result_o,
  output logic     nv_o
);
  fp_word_t fa, fb;
  logic     a_lt_b, b_lt_a, ab_eq;
  logic     a_nan, b_nan, any_snan;

  assign fa       = flush(src_a_i);
  assign fb       = flush(src_b_i);
  assign a_nan    = is_nan(fa);
  assign b_nan    = is_nan(fb);
  assign any_snan = is_snan(fa) || is_snan(fb);
  assign a_lt_b   = fp_lt(fa, fb);
  assign b_lt_a   = fp_lt(fb, fa);
  assign ab_eq    = fp_eq(fa, fb);

  always_comb begin
    result_o = '0;
    nv_o     = 1'b0;
    unique case (op_i)
      OP_MIN, OP_MAX: begin
        nv_o = any_snan;
        if (a_nan && b_nan)      result_o = CANON_NAN;
        else if (a_nan)          result_o = fb;
        else if (b_nan)          result_o = fa;
        else if (op_i == OP_MIN) result_o = a_lt_b ? fa : (b_lt_a ? fb : (fa[SIGN_BIT] ? fa : fb));
        else                     result_o = b_lt_a ? fa : (a_lt_b ? fb : (fa[SIGN_BIT] ? fb : fa));
      end
      OP_FEQ: begin
        nv_o     = any_snan;
        result_o = {{(FP_W-1){1'b0}}, ab_eq};
      end
      OP_FLT: begin
        nv_o     = a_nan || b_nan;
        result_o = {{(FP_W-1){1'b0}}, a_lt_b};
      end
      OP_FLE: begin
        nv_o     = a_nan || b_nan;
        result_o = {{(FP_W-1){1'b0}}, a_lt_b || ab_eq};
      end
      OP_SGNJ:  result_o = {fb[SIGN_BIT],               fa[SIGN_BIT-1:0]};
      OP_SGNJN: result_o = {~fb[SIGN_BIT],              fa[SIGN_BIT-1:0]};
      OP_SGNJX: result_o = {fa[SIGN_BIT] ^ fb[SIGN_BIT], fa[SIGN_BIT-1:0]};
      OP_CLASS: result_o = {{(FP_W-CLASS_W){1'b0}}, classify(fa)};
      default:  result_o = '0;
    endcase
  end

  // classify mask is one-hot and never names a subnormal class
  p_class_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CLASS) |-> ($countones(result_o[CLASS_W-1:0]) == 1 &&
                            result_o[FP_W-1:CLASS_W] == '0 &&
                            !result_o[2] && !result_o[5]));

  // compares yield a pure boolean word
  p_cmp_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FEQ || op_i == OP_FLT || op_i == OP_FLE) |-> (result_o[FP_W-1:1] == '0));

  // min/max picks one of the flushed operands unless both are NaN
  p_minmax_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_MIN || op_i == OP_MAX) && !(a_nan && b_nan)) |-> (result_o == fa || result_o == fb));
endmodule

// File: rtl/fpcs_sticky.sv
module fpcs_sticky
  import fpcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en_i,
  input  logic [FLAG_W-1:0] set_bits_i,
  input  logic              clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] new_bits;

  assign new_bits = set_en_i ? set_bits_i : '0;
  assign flags_o  = flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (clr_i) flags_q <= new_bits;
    else            flags_q <= flags_q | new_bits;
  end

  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_en_i) |=> $stable(flags_q));

  p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_en_i) |=> (flags_q == '0));

  p_only_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FLAG_W-1:FLG_NV+1] == '0);
endmodule

// File: rtl/fp_cmpsel.sv
module fp_cmpsel
  import fpcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [6:0]  funct7,
  input  logic [2:0]  funct3,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic        flag_clr,
  output logic [31:0] result,
  output logic        illegal_op,
  output logic [4:0]  fflags
);
  op_e               op_sel;
  logic              op_legal;
  fp_word_t          core_res;
  logic              core_nv;
  logic              flag_set_en;
  logic [FLAG_W-1:0] flag_set_bits;

  fpcs_decode u_dec (
    .funct7_i (funct7),
    .funct3_i (funct3),
    .op_o     (op_sel),
    .legal_o  (op_legal)
  );

  fpcs_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_sel),
    .src_a_i  (src_a),
    .src_b_i  (src_b),
    .result_o (core_res),
    .nv_o     (core_nv)
  );

  always_comb begin
    flag_set_bits         = '0;
    flag_set_bits[FLG_NV] = core_nv;
  end
  assign flag_set_en = op_valid && op_legal;

  fpcs_sticky u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en_i   (flag_set_en),
    .set_bits_i (flag_set_bits),
    .clr_i      (flag_clr),
    .flags_o    (fflags)
  );

  assign result     = core_res;
  assign illegal_op = !op_legal;

  p_illegal_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (result == '0));
endmodule

// File: tb/sim_fp_cmpsel.sv
module sim_fp_cmpsel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [6:0]  funct7 = '0;
  logic [2:0]  funct3 = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] result;
  logic        illegal_op;
  logic [4:0]  fflags;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [4:0] mdl_flags = '0;
  bit last_clr = 0;

  always #4 clk = ~clk;

  fp_cmpsel u0 (.*);

  function automatic logic [31:0] m_fl(logic [31:0] x);
    return (x[30:23] == 8'd0) ? {x[31], 31'd0} : x;
  endfunction
  function automatic bit m_nan(logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic bit m_snan(logic [31:0] x);
    return m_nan(x) && x[22] == 1'b0;
  endfunction
  // signed ordering key: both zeros map to 0
  function automatic longint m_key(logic [31:0] x);
    longint mag;
    mag = longint'(x[30:0]);
    return x[31] ? -mag : mag;
  endfunction
  function automatic bit m_legal(logic [6:0] f7, logic [2:0] f3);
    case ({f7, f3})
      10'b0010100_000, 10'b0010100_001, 10'b1010000_010, 10'b1010000_001,
      10'b1010000_000, 10'b0010000_000, 10'b0010000_001, 10'b0010000_010,
      10'b1110000_001: return 1;
      default: return 0;
    endcase
  endfunction
  function automatic logic [31:0] m_res(logic [6:0] f7, logic [2:0] f3, logic [31:0] a0, logic [31:0] b0);
    logic [31:0] a, b;
    bit nan_any;
    int idx;
    a = m_fl(a0); b = m_fl(b0);
    nan_any = m_nan(a) || m_nan(b);
    case ({f7, f3})
      10'b0010100_000, 10'b0010100_001: begin
        if (m_nan(a) && m_nan(b)) return 32'h7FC00000;
        if (m_nan(a)) return b;
        if (m_nan(b)) return a;
        if (m_key(a) == m_key(b)) begin
          if (f3 == 3'b000) return a[31] ? a : b;
          return a[31] ? b : a;
        end
        if (f3 == 3'b000) return (m_key(a) < m_key(b)) ? a : b;
        return (m_key(a) > m_key(b)) ? a : b;
      end
      10'b1010000_010: return (!nan_any && m_key(a) == m_key(b)) ? 32'd1 : 32'd0;
      10'b1010000_001: return (!nan_any && m_key(a) <  m_key(b)) ? 32'd1 : 32'd0;
      10'b1010000_000: return (!nan_any && m_key(a) <= m_key(b)) ? 32'd1 : 32'd0;
      10'b0010000_000: return {b[31], a[30:0]};
      10'b0010000_001: return {!b[31], a[30:0]};
      10'b0010000_010: return {a[31] ^ b[31], a[30:0]};
      10'b1110000_001: begin
        if (a[30:23] == 8'hFF) idx = (a[22:0] == 0) ? (a[31] ? 0 : 7) : (a[22] ? 9 : 8);
        else if (a[30:0] == 0) idx = a[31] ? 3 : 4;
        else idx = a[31] ? 1 : 6;
        return 32'd1 << idx;
      end
      default: return 32'd0;
    endcase
  endfunction
  function automatic bit m_inv(logic [6:0] f7, logic [2:0] f3, logic [31:0] a, logic [31:0] b);
    if (f7 == 7'b0010100 && (f3 == 3'b000 || f3 == 3'b001)) return m_snan(a) || m_snan(b);
    if (f7 == 7'b1010000 && f3 == 3'b010) return m_snan(a) || m_snan(b);
    if (f7 == 7'b1010000 && (f3 == 3'b001 || f3 == 3'b000)) return m_nan(a) || m_nan(b);
    return 0;
  endfunction
  function automatic string m_tag(logic [6:0] f7);
    case (f7)
      7'b0010100: return "R3/R4";
      7'b1010000: return "R5";
      7'b0010000: return "R6";
      7'b1110000: return "R7";
      default:    return "R1";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [6:0] f7, logic [2:0] f3, logic [31:0] a, logic [31:0] b,
                        bit v, bit c, bit use_lit, logic [31:0] lit, string lit_req);
    logic [4:0] nb;
    @(negedge clk);
    funct7 = f7; funct3 = f3; src_a = a; src_b = b; op_valid = v; flag_clr = c;
    #1;
    check(m_tag(f7), result, m_res(f7, f3, a, b));
    check("R1", {31'd0, illegal_op}, {31'd0, !m_legal(f7, f3)});
    check(last_clr ? "R10" : "R9/R8", {27'd0, fflags}, {27'd0, mdl_flags});
    if (use_lit) check(lit_req, result, lit);
    @(posedge clk);
    nb = (v && m_legal(f7, f3)) ? {4'd0, m_inv(f7, f3, a, b)} : 5'd0;
    mdl_flags = c ? nb : (mdl_flags | nb);
    last_clr = c;
  endtask

  function automatic logic [31:0] pick_val(int k, logic [31:0] r);
    logic [7:0] e;
    e = (r[30:23] == 8'd0) ? 8'd1 : ((r[30:23] == 8'hFF) ? 8'hFE : r[30:23]);
    case (k)
      0: return {r[31], 31'd0};
      1: return {r[31], 8'hFF, 23'd0};
      2: return {r[31], 8'hFF, 1'b1, r[21:0]};
      3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      4: return {r[31], 8'h00, r[22:1], 1'b1};
      5, 6: return {r[31], e, r[22:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R11", {27'd0, fflags}, 32'd0);

    // directed corners
    run_op(7'b0010100, 3'b000, 32'h80000000, 32'h00000000, 1, 0, 1, 32'h80000000, "R4");
    run_op(7'b0010100, 3'b000, 32'h00000000, 32'h80000000, 1, 0, 1, 32'h80000000, "R4");
    run_op(7'b0010100, 3'b001, 32'h80000000, 32'h00000000, 1, 0, 1, 32'h00000000, "R4");
    run_op(7'b0010100, 3'b001, 32'h7FC00000, 32'h40A00000, 1, 0, 1, 32'h40A00000, "R3");
    run_op(7'b0010100, 3'b000, 32'h7F800001, 32'hFFC00000, 1, 0, 1, 32'h7FC00000, "R3");
    run_op(7'b1110000, 3'b001, 32'h00000123, 32'h0, 1, 0, 1, 32'h00000010, "R2");
    run_op(7'b1110000, 3'b001, 32'h807FFFFF, 32'h0, 1, 0, 1, 32'h00000008, "R7");
    run_op(7'b1010000, 3'b010, 32'h00000005, 32'h80000000, 1, 0, 1, 32'd1, "R2");
    run_op(7'b1010000, 3'b010, 32'h7FC00000, 32'h7FC00000, 1, 0, 1, 32'd0, "R5");
    run_op(7'b1010000, 3'b001, 32'hBF800000, 32'h3F800000, 1, 0, 1, 32'd1, "R5");
    run_op(7'b0010000, 3'b010, 32'hBF800000, 32'hBF800000, 1, 0, 1, 32'h3F800000, "R6");
    run_op(7'b0000000, 3'b000, 32'h3F800000, 32'h3F800000, 1, 0, 1, 32'd0, "R1");
    run_op(7'b1010000, 3'b001, 32'h7FC00000, 32'h3F800000, 1, 0, 1, 32'd0, "R8");
    run_op(7'b0010000, 3'b000, 32'h0, 32'h0, 1, 1, 0, 0, "");
    run_op(7'b0010000, 3'b000, 32'h0, 32'h0, 1, 0, 1, 32'h0, "R10");
    run_op(7'b1010000, 3'b010, 32'h7F800001, 32'h0, 1, 1, 0, 0, "");
    run_op(7'b1111111, 3'b111, 32'h7F800001, 32'h0, 1, 0, 0, 0, "");
    run_op(7'b1010000, 3'b000, 32'h7F800001, 32'h0, 0, 0, 0, 0, "");
    run_op(7'b0010000, 3'b000, 32'h0, 32'h0, 1, 0, 0, 0, "");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] f7; logic [2:0] f3; logic [31:0] a, b; int sel;
      sel = int'($urandom_range(0, 10));
      case (sel)
        0: begin f7 = 7'b0010100; f3 = 3'b000; end
        1: begin f7 = 7'b0010100; f3 = 3'b001; end
        2: begin f7 = 7'b1010000; f3 = 3'b010; end
        3: begin f7 = 7'b1010000; f3 = 3'b001; end
        4: begin f7 = 7'b1010000; f3 = 3'b000; end
        5: begin f7 = 7'b0010000; f3 = 3'(3'($urandom_range(0, 2))); end
        6, 7: begin f7 = 7'b1110000; f3 = 3'b001; end
        default: begin f7 = 7'($urandom); f3 = 3'($urandom); end
      endcase
      a = pick_val(int'($urandom_range(0, 7)), $urandom);
      case ($urandom_range(0, 3))
        0: b = a;
        1: b = {~a[31], a[30:0]};
        default: b = pick_val(int'($urandom_range(0, 7)), $urandom);
      endcase
      run_op(f7, f3, a, b, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0), 0, 0, "");
    end

    @(negedge clk);
    check("R9/R10", {27'd0, fflags}, {27'd0, mdl_flags});
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule